// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The block turns a 32-bit virtual address into a physical address by reading up to two descriptors from a translation table in memory. A request carries the virtual address, a user/kernel flag and a read/write flag, together with a table base and a 32-bit domain control word. The block is busy from the moment it accepts a request until it delivers one result. While busy it issues single-word reads on a memory port and consumes their responses. The memory may answer after any latency of one cycle or more.

The first-level descriptor either maps a 1 MB region directly or points to a second-level table. There are two kinds of second-level table. The short kind has 256 entries and maps 64 KB and 4 KB pages. The long kind has 1024 entries and also maps 1 KB pages. Large and small pages are split into four quarters, and each quarter has its own permission field. The domain number comes from the first-level descriptor and selects a 2-bit mode from the domain control word. That mode either blocks the access, enforces the page permission, or bypasses the permission check. The result gives the physical address, the cacheable and bufferable attributes, and a fault code.

Top module: `mmu_walker`

## Requirements
- R1: While rst_ni is low and after its release with no request, busy_o, rsp_valid_o and mem_req_o are 0.
- R2: The first read of a walk goes to {ttb_i[31:14], va[31:20], 2'b00}, using the values present when the request was accepted; ttb_i[13:0] has no effect.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk after one read with fault code 1 (section translation fault).
- R4: First-level type 10 maps a section: pa = {desc[31:20], va[19:0]}, cacheable = desc[3], bufferable = desc[2], domain = desc[8:5], permission = desc[11:10]; there is no second read.
- R5: First-level type 01 selects a short table, read at {desc[31:10], va[19:12], 2'b00}. Type 11 selects a long table, read at {desc[31:12], va[19:10], 2'b00}.
- R6: A second-level descriptor with bits [1:0] = 00, or with type 11 in a short table, gives fault code 2 (page translation fault). A translation fault takes priority over domain and permission checks.
- R7: Second-level type 01 (64 KB) gives pa = {d[31:16], va[15:0]}, type 10 (4 KB) gives {d[31:12], va[11:0]}, and type 11 (1 KB) gives {d[31:10], va[9:0]}. For all three, cacheable = d[3] and bufferable = d[2].
- R8: A second-level descriptor holds four 2-bit permission fields at d[5:4], d[7:6], d[9:8] and d[11:10], for quarters 0 to 3. A 64 KB page takes the quarter from va[15:14], a 4 KB page from va[11:10], and a 1 KB page always uses d[5:4].
- R9: The domain mode is dac_i[2*dom+1 : 2*dom]. Mode 00 or 10 gives fault code 3 (domain fault). Mode 11 grants access with no permission check. Mode 01 applies R10.
- R10: Permission codes: 00 kernel read only, 01 kernel read/write, 10 adds user read, 11 full read/write. Any access outside the code's rights gives fault code 4 (permission fault).
- R11: When the fault code is nonzero, rsp_pa_o, rsp_cacheable_o and rsp_bufferable_o are 0. Fault code 0 means success.
- R12: rsp_valid_o is a one-cycle pulse, one cycle after the cycle in which the final read response is taken. mem_req_o is a one-cycle pulse, and a new read is issued only after the previous one has been answered. busy_o is high from the cycle after acceptance through the result pulse.
- R13: req_valid_i is ignored while busy_o is high. Such a request neither changes the result in progress nor starts any further reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request, taken when not busy |
| req_va_i | input | 32 | Virtual address |
| req_user_i | input | 1 | 1 = user access, 0 = kernel access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| ttb_i | input | 32 | Table base; bits [31:14] used |
| dac_i | input | 32 | Sixteen 2-bit domain modes |
| busy_o | output | 1 | Walk in progress |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_pa_o | output | 32 | Physical address |
| rsp_cacheable_o | output | 1 | Cacheable attribute |
| rsp_bufferable_o | output | 1 | Bufferable attribute |
| rsp_fault_o | output | 3 | 0 none, 1 section xlat, 2 page xlat, 3 domain, 4 permission |
| mem_req_o | output | 1 | Descriptor read strobe |
| mem_addr_o | output | 32 | Descriptor word address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor read data |

## Verification
The first read strobe appears in the cycle after acceptance. Each later strobe follows one cycle after the previous response. The result pulse comes exactly one cycle after the final response, so a section or first-level fault is due at response plus one, and a page result at the second response plus one. The bench counts cycles with its own memory model, which records the cycle of each response and the address of each read. Each result is sampled at the mid-cycle point and required in exactly the following cycle. One cycle later the bench also checks that busy_o has fallen, which confirms that no extra read or second result took place. Sweeps cover every descriptor type, permission code, quarter, privilege, direction and domain mode, with memory latencies of 1 to 3 cycles.

// File: rtl/mmu_walk_pkg.sv
package mmu_walk_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned DOM_W       = 4;
  localparam int unsigned DOM_CNT     = 1 << DOM_W;
  localparam int unsigned AP_W        = 2;
  localparam int unsigned SUBPG_CNT   = 4;
  localparam int unsigned L1_BASE_LSB = 14;
  localparam int unsigned SECT_SHIFT  = 20;
  localparam int unsigned LARGE_SHIFT = 16;
  localparam int unsigned SMALL_SHIFT = 12;
  localparam int unsigned TINY_SHIFT  = 10;
  localparam int unsigned AP_LSB      = 4;

  typedef enum logic [1:0] {
    L1_FAULT   = 2'b00,
    L1_COARSE  = 2'b01,
    L1_SECTION = 2'b10,
    L1_FINE    = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2_FAULT = 2'b00,
    L2_LARGE = 2'b01,
    L2_SMALL = 2'b10,
    L2_TINY  = 2'b11
  } l2_kind_e;

  typedef enum logic [1:0] {
    DOM_NOACC   = 2'b00,
    DOM_CLIENT  = 2'b01,
    DOM_RSVD    = 2'b10,
    DOM_MANAGER = 2'b11
  } dom_mode_e;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_SECT_XLAT = 3'd1,
    FLT_PAGE_XLAT = 3'd2,
    FLT_DOMAIN    = 3'd3,
    FLT_PERM      = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] pa;
    logic              cacheable;
    logic              bufferable;
    fault_e            fault;
  } walk_result_t;

  function automatic logic ap_allows(logic [AP_W-1:0] ap, logic user, logic write);
    logic ok;
    unique case (ap)
      2'b00:   ok = !user && !write;
      2'b01:   ok = !user;
      2'b10:   ok = !user || !write;
      default: ok = 1'b1;
    endcase
    return ok;
  endfunction

  function automatic walk_result_t make_result(fault_e f, logic [ADDR_W-1:0] pa,
                                               logic c, logic b);
    walk_result_t r;
    r.fault      = f;
    r.pa         = (f == FLT_NONE) ? pa : '0;
    r.cacheable  = (f == FLT_NONE) && c;
    r.bufferable = (f == FLT_NONE) && b;
    return r;
  endfunction
endpackage

// File: rtl/mmu_l1_decode.sv
module mmu_l1_decode
  import mmu_walk_pkg::*;
(
  input  logic [ADDR_W-1:0]     desc_i,
  input  logic [SECT_SHIFT-1:0] va_low_i,
  output l1_kind_e              kind_o,
  output logic [ADDR_W-1:0]     sect_pa_o,
  output logic [ADDR_W-1:0]     l2_addr_o,
  output logic [DOM_W-1:0]      dom_o,
  output logic [AP_W-1:0]       ap_o,
  output logic                  c_o,
  output logic                  b_o
);
  localparam int unsigned COARSE_IDX_W = SECT_SHIFT - SMALL_SHIFT;
  localparam int unsigned FINE_IDX_W   = SECT_SHIFT - TINY_SHIFT;

  logic [ADDR_W-1:0] coarse_addr, fine_addr;
  logic              unused_imp;

  assign kind_o    = l1_kind_e'(desc_i[1:0]);
  assign sect_pa_o = {desc_i[ADDR_W-1:SECT_SHIFT], va_low_i};
  assign dom_o     = desc_i[5 +: DOM_W];
  assign ap_o      = desc_i[10 +: AP_W];
  assign c_o       = desc_i[3];
  assign b_o       = desc_i[2];
  assign unused_imp = desc_i[4];

  // short table: 1 KB aligned, 256 words; long table: 4 KB aligned, 1024 words
  assign coarse_addr = {desc_i[ADDR_W-1:TINY_SHIFT],
                        va_low_i[SMALL_SHIFT +: COARSE_IDX_W], 2'b00};
  assign fine_addr   = {desc_i[ADDR_W-1:SMALL_SHIFT],
                        va_low_i[TINY_SHIFT +: FINE_IDX_W], 2'b00};
  assign l2_addr_o   = (kind_o == L1_COARSE) ? coarse_addr : fine_addr;
endmodule

// File: rtl/mmu_l2_decode.sv
module mmu_l2_decode
  import mmu_walk_pkg::*;
(
  input  logic [ADDR_W-1:0]     desc_i,
  input  logic [SECT_SHIFT-1:0] va_low_i,
  input  logic                  fine_i,
  output logic                  valid_o,
  output logic [ADDR_W-1:0]     pa_o,
  output logic [AP_W-1:0]       ap_o,
  output logic                  c_o,
  output logic                  b_o
);
  l2_kind_e        kind;
  logic [AP_W-1:0] ap_fld [SUBPG_CNT];

  for (genvar k = 0; k < SUBPG_CNT; k++) begin : g_ap
    assign ap_fld[k] = desc_i[AP_LSB + AP_W*k +: AP_W];
  end

  assign kind = l2_kind_e'(desc_i[1:0]);
  assign c_o  = desc_i[3];
  assign b_o  = desc_i[2];

  always_comb begin
    valid_o = 1'b1;
    pa_o    = '0;
    ap_o    = ap_fld[0];
    unique case (kind)
      L2_LARGE: begin
        pa_o = {desc_i[ADDR_W-1:LARGE_SHIFT], va_low_i[LARGE_SHIFT-1:0]};
        ap_o = ap_fld[va_low_i[LARGE_SHIFT-2 +: 2]];
      end
      L2_SMALL: begin
        pa_o = {desc_i[ADDR_W-1:SMALL_SHIFT], va_low_i[SMALL_SHIFT-1:0]};
        ap_o = ap_fld[va_low_i[SMALL_SHIFT-2 +: 2]];
      end
      L2_TINY: begin
        pa_o    = {desc_i[ADDR_W-1:TINY_SHIFT], va_low_i[TINY_SHIFT-1:0]};
        valid_o = fine_i;  // tiny pages exist only in long tables
      end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
  import mmu_walk_pkg::*;
(
  input  logic [ADDR_W-1:0] dac_i,
  input  logic [DOM_W-1:0]  dom_i,
  input  logic [AP_W-1:0]   ap_i,
  input  logic              user_i,
  input  logic              write_i,
  output fault_e            fault_o
);
  dom_mode_e modes [DOM_CNT];

  for (genvar g = 0; g < DOM_CNT; g++) begin : g_dom
    assign modes[g] = dom_mode_e'(dac_i[2*g +: 2]);
  end

  always_comb begin
    unique case (modes[dom_i])
      DOM_MANAGER: fault_o = FLT_NONE;
      DOM_CLIENT:  fault_o = ap_allows(ap_i, user_i, write_i) ? FLT_NONE : FLT_PERM;
      default:     fault_o = FLT_DOMAIN;
    endcase
  end
endmodule

// File: rtl/mmu_walker.sv
module mmu_walker
  import mmu_walk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [31:0]       req_va_i,
  input  logic              req_user_i,
  input  logic              req_write_i,
  input  logic [31:0]       ttb_i,
  input  logic [31:0]       dac_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_pa_o,
  output logic              rsp_cacheable_o,
  output logic              rsp_bufferable_o,
  output logic [2:0]        rsp_fault_o,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [31:0]       mem_rdata_i
);
  localparam int unsigned TTB_W = ADDR_W - L1_BASE_LSB;
  localparam int unsigned VIDX_W = ADDR_W - SECT_SHIFT;

  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] va_q;
  logic              user_q, write_q, fine_q;
  logic [TTB_W-1:0]  ttb_q;
  logic [ADDR_W-1:0] dac_q;
  logic [ADDR_W-1:0] l2_addr_q;
  logic [DOM_W-1:0]  dom_q;
  walk_result_t      res_q, res_d;
  logic              accept, l1_take, l2_take;
  logic [L1_BASE_LSB-1:0] unused_ttb;

  l1_kind_e          l1_kind;
  logic [ADDR_W-1:0] l1_sect_pa, l1_l2_addr, l2_pa;
  logic [DOM_W-1:0]  l1_dom, chk_dom;
  logic [AP_W-1:0]   l1_ap, l2_ap, chk_ap;
  logic              l1_c, l1_b, l2_c, l2_b, l2_valid;
  fault_e            chk_fault;

  assign unused_ttb = ttb_i[L1_BASE_LSB-1:0];

  mmu_l1_decode u_l1_dec (
    .desc_i    (mem_rdata_i),
    .va_low_i  (va_q[SECT_SHIFT-1:0]),
    .kind_o    (l1_kind),
    .sect_pa_o (l1_sect_pa),
    .l2_addr_o (l1_l2_addr),
    .dom_o     (l1_dom),
    .ap_o      (l1_ap),
    .c_o       (l1_c),
    .b_o       (l1_b)
  );

  mmu_l2_decode u_l2_dec (
    .desc_i   (mem_rdata_i),
    .va_low_i (va_q[SECT_SHIFT-1:0]),
    .fine_i   (fine_q),
    .valid_o  (l2_valid),
    .pa_o     (l2_pa),
    .ap_o     (l2_ap),
    .c_o      (l2_c),
    .b_o      (l2_b)
  );

  // one checker shared by the section path and the page path
  assign chk_dom = (state_q == ST_L2_WAIT) ? dom_q : l1_dom;
  assign chk_ap  = (state_q == ST_L2_WAIT) ? l2_ap : l1_ap;

  mmu_access_check u_acc (
    .dac_i   (dac_q),
    .dom_i   (chk_dom),
    .ap_i    (chk_ap),
    .user_i  (user_q),
    .write_i (write_q),
    .fault_o (chk_fault)
  );

  assign accept  = (state_q == ST_IDLE) && req_valid_i;
  assign l1_take = (state_q == ST_L1_WAIT) && mem_rsp_valid_i;
  assign l2_take = (state_q == ST_L2_WAIT) && mem_rsp_valid_i;

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = ST_L1_REQ;
      ST_L1_REQ: state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rsp_valid_i) begin
        unique case (l1_kind)
          L1_FAULT: begin
            res_d   = make_result(FLT_SECT_XLAT, '0, 1'b0, 1'b0);
            state_d = ST_DONE;
          end
          L1_SECTION: begin
            res_d   = make_result(chk_fault, l1_sect_pa, l1_c, l1_b);
            state_d = ST_DONE;
          end
          default: state_d = ST_L2_REQ;
        endcase
      end
      ST_L2_REQ: state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rsp_valid_i) begin
        res_d   = l2_valid ? make_result(chk_fault, l2_pa, l2_c, l2_b)
                           : make_result(FLT_PAGE_XLAT, '0, 1'b0, 1'b0);
        state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q    <= '0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
      ttb_q   <= '0;
      dac_q   <= '0;
    end else if (accept) begin
      va_q    <= req_va_i;
      user_q  <= req_user_i;
      write_q <= req_write_i;
      ttb_q   <= ttb_i[ADDR_W-1:L1_BASE_LSB];
      dac_q   <= dac_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l2_addr_q <= '0;
      dom_q     <= '0;
      fine_q    <= 1'b0;
    end else if (l1_take) begin
      l2_addr_q <= l1_l2_addr;
      dom_q     <= l1_dom;
      fine_q    <= (l1_kind == L1_FINE);
    end
  end

  assign busy_o           = (state_q != ST_IDLE);
  assign rsp_valid_o      = (state_q == ST_DONE);
  assign rsp_pa_o         = res_q.pa;
  assign rsp_cacheable_o  = res_q.cacheable;
  assign rsp_bufferable_o = res_q.bufferable;
  assign rsp_fault_o      = res_q.fault;
  assign mem_req_o        = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr_o       = (state_q == ST_L2_REQ) ? l2_addr_q
                          : {ttb_q, va_q[ADDR_W-1 -: VIDX_W], 2'b00};

  logic unused_take;
  assign unused_take = l2_take;
endmodule

// File: rtl/mmu_walker_chk.sv
module mmu_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] req_va_i,
  input logic        req_user_i,
  input logic        req_write_i,
  input logic [31:0] ttb_i,
  input logic [31:0] dac_i,
  input logic        busy_o,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_pa_o,
  input logic        rsp_cacheable_o,
  input logic        rsp_bufferable_o,
  input logic [2:0]  rsp_fault_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rsp_valid_i,
  input logic [31:0] mem_rdata_i
);
  logic unused_chk;
  assign unused_chk = ^{req_user_i, req_write_i, dac_i, mem_rdata_i, ttb_i[13:0]};

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !rsp_valid_o));

  assert_l1_fetch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mem_req_o &&
      mem_addr_o == {$past(ttb_i[31:14]), $past(req_va_i[31:20]), 2'b00}));

  assert_start_on_req_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));

  assert_word_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_fault_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fault_o <= 3'd4));

  assert_fault_zeroes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 3'd0) |->
      (rsp_pa_o == 32'd0 && !rsp_cacheable_o && !rsp_bufferable_o));

  assert_rsp_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_rsp_after_mem_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(mem_rsp_valid_i));

  assert_req_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  assert_req_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

bind mmu_walker mmu_walker_chk u_chk (.*);

// File: tb/mmu_walker_tb.sv
module mmu_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_user = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] ttb = '0;
  logic [31:0] dac = '0;
  logic        busy, rsp_valid, rsp_c, rsp_b, mem_req;
  logic [31:0] rsp_pa, mem_addr;
  logic [2:0]  rsp_fault;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mmu_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_va_i(req_va),
    .req_user_i(req_user), .req_write_i(req_write), .ttb_i(ttb), .dac_i(dac),
    .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa),
    .rsp_cacheable_o(rsp_c), .rsp_bufferable_o(rsp_b), .rsp_fault_o(rsp_fault),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rdata_i(mem_rdata)
  );

  // memory model: acts 1 ns after each rising edge
  logic [31:0] m_l1addr, m_l1, m_l2addr, m_l2;
  int m_lat = 1, m_reads = 0, cnt = 0, cyc = 0, last_rsp_cyc = -10;
  bit m_bad_l1 = 0, m_bad_l2 = 0, pending = 0;
  logic [31:0] cur_addr;

  always begin
    @(posedge clk); #1;
    cyc++;
    mem_rsp_valid = 1'b0;
    if (pending) begin
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        pending = 0;
        last_rsp_cyc = cyc;
        if (m_reads == 1) begin
          if (cur_addr != m_l1addr) m_bad_l1 = 1;
          mem_rdata = m_l1;
        end else begin
          if (cur_addr != m_l2addr) m_bad_l2 = 1;
          mem_rdata = m_l2;
        end
      end else cnt--;
    end
    if (mem_req) begin
      pending = 1;
      cnt = m_lat - 1;
      cur_addr = mem_addr;
      m_reads++;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] acc_exp(logic [31:0] d, logic [3:0] dom, logic [1:0] ap,
                                         bit u, bit w);
    logic [1:0] m;
    bit ok;
    m = d[2*dom +: 2];
    if (m == 2'b00 || m == 2'b10) return 3'd3;
    if (m == 2'b11) return 3'd0;
    ok = u ? (ap == 2'b11 || (ap == 2'b10 && !w)) : (ap != 2'b00 || !w);
    return ok ? 3'd0 : 3'd4;
  endfunction

  task automatic run(logic [31:0] va, logic [31:0] tb_ttb, logic [31:0] tb_dac,
                     logic [31:0] l1, logic [31:0] l2, bit u, bit w, int lat, bit inject);
    logic [2:0]  ef;
    logic [31:0] epa;
    logic        ec, eb;
    logic [1:0]  ap;
    int          ereads, n;
    string       tag;
    ef = 0; epa = 0; ec = 0; eb = 0; ereads = 1; ap = 0;
    m_l1addr = {tb_ttb[31:14], va[31:20], 2'b00};
    m_l1 = l1; m_l2 = l2; m_lat = lat;
    m_l2addr = (l1[1:0] == 2'b01) ? {l1[31:10], va[19:12], 2'b00}
                                  : {l1[31:12], va[19:10], 2'b00};
    if (l1[1:0] == 2'b00) begin
      ef = 3'd1; tag = "R3";
    end else if (l1[1:0] == 2'b10) begin
      tag = "R4";
      ef = acc_exp(tb_dac, l1[8:5], l1[11:10], u, w);
      epa = {l1[31:20], va[19:0]}; ec = l1[3]; eb = l1[2];
    end else begin
      ereads = 2; tag = "R7";
      if (l2[1:0] == 2'b00 || (l1[1:0] == 2'b01 && l2[1:0] == 2'b11)) begin
        ef = 3'd2; tag = "R6";
      end else begin
        case (l2[1:0])
          2'b01: begin epa = {l2[31:16], va[15:0]}; ap = l2[4 + 2*va[15:14] +: 2]; end
          2'b10: begin epa = {l2[31:12], va[11:0]}; ap = l2[4 + 2*va[11:10] +: 2]; end
          default: begin epa = {l2[31:10], va[9:0]}; ap = l2[5:4]; end
        endcase
        // R8: subpage permission selected above
        ef = acc_exp(tb_dac, l1[8:5], ap, u, w);
        ec = l2[3]; eb = l2[2];
      end
    end
    if (ef == 3'd3) tag = "R9";
    if (ef == 3'd4) tag = (ereads == 2) ? "R8/R10" : "R10";
    if (ef != 0) begin epa = 0; ec = 0; eb = 0; end

    @(negedge clk);
    m_reads = 0; m_bad_l1 = 0; m_bad_l2 = 0;
    req_valid = 1'b1; req_va = va; ttb = tb_ttb; dac = tb_dac; req_user = u; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    // scramble inputs: result must use values captured at acceptance (R2)
    req_va = ~va; ttb = ~tb_ttb; dac = ~tb_dac; req_user = ~u; req_write = ~w;
    n = 0;
    while (!rsp_valid && n < 60) begin
      @(negedge clk);
      n++;
      req_valid = (inject && n == 2);  // R13: request while busy
    end
    req_valid = 1'b0;
    chk(n < 60, "R12", "result arrived", n, 0);
    chk(cyc == last_rsp_cyc + 1, "R12", "result one cycle after response", cyc, last_rsp_cyc + 1);
    chk(rsp_fault == ef, tag, "fault", rsp_fault, ef);
    chk(rsp_pa == epa, (ef != 0) ? "R11" : tag, "pa", rsp_pa, epa);
    chk({rsp_c, rsp_b} == {ec, eb}, (ef != 0) ? "R11" : tag, "c/b", {rsp_c, rsp_b}, {ec, eb});
    chk(m_reads == ereads, inject ? "R13" : tag, "read count", m_reads, ereads);
    chk(!m_bad_l1, "R2", "first-level address", cur_addr, m_l1addr);
    chk(!m_bad_l2, "R5", "second-level address", cur_addr, m_l2addr);
    @(negedge clk);
    chk(!rsp_valid && !busy, inject ? "R13" : "R12", "idle after pulse", {rsp_valid, busy}, 0);
    chk(m_reads == ereads, inject ? "R13" : "R12", "no extra read", m_reads, ereads);
  endtask

  function automatic logic [31:0] mk_dac(logic [3:0] dom, logic [1:0] dt);
    logic [31:0] d;
    for (int k = 0; k < 16; k++) d[2*k +: 2] = (k == dom) ? dt : 2'(dt + 2'd1);
    return d;
  endfunction

  initial begin
    int idx;
    logic [3:0] dom;
    logic [31:0] va, l1, l2, tt;
    // R1: reset state
    #2;
    chk(!busy && !rsp_valid && !mem_req, "R1", "outputs in reset", {busy, rsp_valid, mem_req}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !rsp_valid && !mem_req, "R1", "idle after reset", {busy, rsp_valid, mem_req}, 0);

    // R4, R9, R10: sections across domain mode, permission, privilege, direction
    idx = 0;
    for (int dt = 0; dt < 4; dt++)
      for (int ap = 0; ap < 4; ap++)
        for (int u = 0; u < 2; u++)
          for (int w = 0; w < 2; w++) begin
            dom = 4'(idx);
            va  = {12'(idx * 113 + 7), 20'(idx * 40503 + 'h1234)};
            tt  = {18'(idx * 2971 + 5), 14'(idx * 3 + 1)};
            l1  = {12'(idx * 29 + 3), 8'(idx), 2'(ap), 1'b0, dom, 1'b1,
                   1'(idx), 1'(idx >> 1), 2'b10};
            run(va, tt, mk_dac(dom, 2'(dt)), l1, 32'hFFFF_FFFF, 1'(u), 1'(w), 1 + idx % 3, 0);
            idx++;
          end

    // R3: invalid first-level entries
    for (int i = 0; i < 4; i++)
      run({12'(i * 77), 20'(i * 999)}, {18'(i + 9), 14'h3FFF}, 32'hFFFF_FFFF,
          {30'(i * 12345 + 1), 2'b00}, 32'h0, 1'(i), 1'(i >> 1), 1 + i, 0);

    // R5, R6, R7, R8, R10: both table kinds, all second-level types and quarters
    idx = 0;
    for (int fine = 0; fine < 2; fine++)
      for (int t2 = 0; t2 < 4; t2++)
        for (int sub = 0; sub < 4; sub++)
          for (int u = 0; u < 2; u++)
            for (int w = 0; w < 2; w++)
              for (int mgr = 0; mgr < 2; mgr++) begin
                dom = 4'(idx * 7);
                va  = {12'(idx * 51 + 2), 4'(idx), 2'(sub), 2'(idx >> 2), 2'(sub),
                       10'(idx * 37)};
                tt  = {18'(idx * 613 + 11), 14'(idx)};
                l1  = fine ? {20'(idx * 4093 + 1), 3'b000, dom, 3'b010, 2'b11}
                           : {22'(idx * 8191 + 3), 1'b0, dom, 3'b101, 2'b01};
                l2  = {20'(idx * 3331 + 17), 2'(idx + 3), 2'(idx + 2), 2'(idx + 1),
                       2'(idx), 1'(idx >> 1), 1'(idx >> 2), 2'(t2)};
                run(va, tt, mk_dac(dom, mgr ? 2'b11 : 2'b01), l1, l2, 1'(u), 1'(w),
                    1 + idx % 3, 0);
                idx++;
              end

    // R13: request raised mid-walk is ignored
    run(32'h1234_5678, 32'h0004_0000, 32'hFFFF_FFFF, 32'h8000_0C02, 32'h0, 0, 0, 2, 1);
    run(32'h00A0_3C00, 32'h0008_0000, 32'h5555_5555, 32'h0010_0001, 32'hABCD_1F5E, 1, 0, 3, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule